// File: doc/BRIEF.md
# Transmit Clock Activity Supervisor

This block watches the transmit clock of each of four transmit channels and decides the mode of each channel's transmitter. A channel whose clock toggles is in normal mode. A channel whose clock stays high too long sends all ones. A channel whose clock stays low too long is powered down and its driver is released to high impedance. The stuck-high and stuck-low durations are measured in cycles of a reference clock. The stuck-high limit is 16 cycles and the stuck-low limit is 64 cycles.

The reference is the master clock whenever the master clock is flagged as running. When it is not, the transmit clock of channel 1 takes its place. When neither is available, every channel is held in a tri-stated state. All clock inputs are sampled levels. The block synchronises them into a fast local sampling clock and detects their edges there. The channel in all-ones mode gets a data bit of one and a one-cycle strobe for each reference cycle, so a downstream all-ones generator runs at the reference rate.

Top module: `txsup_top`

## Requirements
- R1: While reset is asserted and after its release, every channel's mode is 2'b00 (normal), its driver enable is 1, and its all-ones data bit is 0.
- R2: A channel whose transmit clock keeps toggling stays in mode 2'b00 with its driver enable at 1.
- R3: A channel whose transmit clock stays high for 16 or more reference rising edges goes to mode 2'b01 (all ones), with all-ones data 1 and driver enable 1. After fewer than 16 such edges it is still 2'b00.
- R4: A channel whose transmit clock stays low for 64 or more reference rising edges goes to mode 2'b10 (power-down), with driver enable 0 and all-ones data 0. After fewer than 64 such edges it is still 2'b00.
- R5: A timed-out channel returns to mode 2'b00 on the first edge of its transmit clock. A channel in 2'b01 never moves straight to 2'b10.
- R6: While the master-clock-present flag is 1, only rising edges of the master clock count as reference cycles. Edges of channel 1's clock do not count.
- R7: While the master-clock-present flag is 0 and the channel-1-present flag is 1, rising edges of channel 1's transmit clock are the reference for both timeouts.
- R8: One cycle after both presence flags are 0, every channel is in mode 2'b11, with driver enable 0 and all-ones data 0. When a reference returns, toggling channels go back to 2'b00.
- R9: In mode 2'b01, the channel's all-ones strobe pulses once for each reference rising edge. In any other mode it stays 0.
- R10: Each channel's mode depends only on its own transmit clock and the reference.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| mclk_in | input | 1 | Master clock level |
| mclk_ok | input | 1 | Master clock is running |
| ch1_ok | input | 1 | Channel 1 transmit clock is available |
| txclk | input | 4 | Transmit clock level for each channel |
| tx_mode | output | 8 | Two-bit mode per channel, channel n at bits 2n+1:2n |
| ones_data | output | 4 | All-ones data bit per channel |
| ones_tick | output | 4 | All-ones strobe per channel, one pulse per reference cycle |
| drv_oe | output | 4 | Line driver output enable per channel |

## Verification
The hardest situation to reach is the fallback reference. The master clock has to be stopped and flagged absent, while channel 1 keeps toggling and another channel's clock is frozen. The stimulus then counts edges of channel 1, not of the master clock, on each side of both thresholds. A second case shows that the master clock wins when it is flagged present. Here the master clock is flagged present but held still, and a frozen channel must stay in normal mode however many channel 1 edges pass. The thresholds are approached by counting reference edges from the bench, stopping a few short and a few beyond, so that synchroniser latency cannot blur the result.

// File: rtl/txsup_pkg.sv
package txsup_pkg;
  typedef enum logic [1:0] {
    MODE_NORM  = 2'b00,
    MODE_ONES  = 2'b01,
    MODE_DOWN  = 2'b10,
    MODE_NOREF = 2'b11
  } tx_mode_e;
endpackage

// File: rtl/txsup_sync.sv
module txsup_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;
  logic [W-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/txsup_refsel.sv
module txsup_refsel (
  input  logic clk,
  input  logic rst_n,
  input  logic mclk_s,
  input  logic ch1_s,
  input  logic mclk_ok,
  input  logic ch1_ok,
  output logic ref_tick,
  output logic ref_valid
);
  logic mclk_prev_q, ch1_prev_q;
  logic mclk_rise, ch1_rise;

  always_comb begin
    mclk_rise = mclk_s & ~mclk_prev_q;
    ch1_rise  = ch1_s & ~ch1_prev_q;
    ref_valid = mclk_ok | ch1_ok;
    if (mclk_ok)     ref_tick = mclk_rise;
    else if (ch1_ok) ref_tick = ch1_rise;
    else             ref_tick = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mclk_prev_q <= 1'b0;
      ch1_prev_q  <= 1'b0;
    end else begin
      mclk_prev_q <= mclk_s;
      ch1_prev_q  <= ch1_s;
    end
  end
endmodule

// File: rtl/txsup_chan.sv
module txsup_chan
  import txsup_pkg::*;
#(
  parameter int HI_LIM = 16,
  parameter int LO_LIM = 64
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     tx_s,
  input  logic     ref_tick,
  input  logic     ref_valid,
  output tx_mode_e mode
);
  localparam int SAT = (LO_LIM > HI_LIM) ? LO_LIM : HI_LIM;
  localparam int CW  = $clog2(SAT + 1);

  logic          prev_q;
  logic [CW-1:0] cnt_q, cnt_d;
  tx_mode_e      mode_q, mode_d;
  logic          edge_seen;
  logic          cnt_en;

  always_comb begin
    edge_seen = tx_s ^ prev_q;
    cnt_en    = ref_tick && (cnt_q < CW'(SAT));
    cnt_d     = cnt_q;
    if (edge_seen)   cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + 1'b1;

    if (!ref_valid)                          mode_d = MODE_NOREF;
    else if (edge_seen)                      mode_d = MODE_NORM;
    else if (tx_s && cnt_q >= CW'(HI_LIM))   mode_d = MODE_ONES;
    else if (!tx_s && cnt_q >= CW'(LO_LIM))  mode_d = MODE_DOWN;
    else                                     mode_d = MODE_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      cnt_q  <= '0;
      mode_q <= MODE_NORM;
    end else begin
      prev_q <= tx_s;
      cnt_q  <= cnt_d;
      mode_q <= mode_d;
    end
  end

  assign mode = mode_q;
endmodule

// File: rtl/txsup_top.sv
module txsup_top
  import txsup_pkg::*;
#(
  parameter int NCH    = 4,
  parameter int REF_CH = 1,
  parameter int HI_LIM = 16,
  parameter int LO_LIM = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mclk_in,
  input  logic             mclk_ok,
  input  logic             ch1_ok,
  input  logic [NCH-1:0]   txclk,
  output logic [2*NCH-1:0] tx_mode,
  output logic [NCH-1:0]   ones_data,
  output logic [NCH-1:0]   ones_tick,
  output logic [NCH-1:0]   drv_oe
);
  localparam int SW = NCH + 1;

  logic          rst_meta_q, rst_q;
  logic [SW-1:0] raw_lv, syn_lv;
  logic          ref_tick, ref_valid;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_q      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q      <= rst_meta_q;
    end
  end

  assign raw_lv = {mclk_in, txclk};

  txsup_sync #(.W(SW)) u_sync (
    .clk(clk), .rst_n(rst_q), .d(raw_lv), .q(syn_lv)
  );

  txsup_refsel u_ref (
    .clk(clk), .rst_n(rst_q),
    .mclk_s(syn_lv[NCH]), .ch1_s(syn_lv[REF_CH]),
    .mclk_ok(mclk_ok), .ch1_ok(ch1_ok),
    .ref_tick(ref_tick), .ref_valid(ref_valid)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tx_mode_e m;
    txsup_chan #(.HI_LIM(HI_LIM), .LO_LIM(LO_LIM)) u_chan (
      .clk(clk), .rst_n(rst_q), .tx_s(syn_lv[i]),
      .ref_tick(ref_tick), .ref_valid(ref_valid), .mode(m)
    );
    always_comb begin
      tx_mode[2*i +: 2] = m;
      ones_data[i]      = (m == MODE_ONES);
      ones_tick[i]      = (m == MODE_ONES) && ref_tick;
      drv_oe[i]         = (m == MODE_NORM) || (m == MODE_ONES);
    end
  end
endmodule

// File: rtl/txsup_chk.sv
module txsup_chk #(
  parameter int NCH = 4
) (
  input logic             clk,
  input logic             rst_q,
  input logic             mclk_ok,
  input logic             ch1_ok,
  input logic [2*NCH-1:0] tx_mode,
  input logic [NCH-1:0]   ones_data,
  input logic [NCH-1:0]   ones_tick,
  input logic [NCH-1:0]   drv_oe
);
  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R8
    noref_mode_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (!mclk_ok && !ch1_ok) |=> (tx_mode[2*i +: 2] == 2'b11));
    // R8
    ref_back_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (mclk_ok || ch1_ok) |=> (tx_mode[2*i +: 2] != 2'b11));
    // R5
    no_ones_to_down_chk: assert property (@(posedge clk) disable iff (!rst_q)
      (tx_mode[2*i +: 2] == 2'b01) |=> (tx_mode[2*i +: 2] != 2'b10));
    // R9
    tick_in_ones_chk: assert property (@(posedge clk) disable iff (!rst_q)
      ones_tick[i] |-> (ones_data[i] && drv_oe[i]));
  end
endmodule

bind txsup_top txsup_chk #(.NCH(NCH)) u_chk (
  .clk(clk), .rst_q(rst_q), .mclk_ok(mclk_ok), .ch1_ok(ch1_ok),
  .tx_mode(tx_mode), .ones_data(ones_data), .ones_tick(ones_tick),
  .drv_oe(drv_oe)
);

// File: tb/txsup_top_test.sv
module txsup_top_test;
  localparam int NCH = 4;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic           rst_n, mclk_in, mclk_ok, ch1_ok;
  logic [NCH-1:0] txclk;
  logic [2*NCH-1:0] tx_mode;
  logic [NCH-1:0] ones_data, ones_tick, drv_oe;

  txsup_top uut (
    .clk(clk), .rst_n(rst_n), .mclk_in(mclk_in), .mclk_ok(mclk_ok),
    .ch1_ok(ch1_ok), .txclk(txclk), .tx_mode(tx_mode),
    .ones_data(ones_data), .ones_tick(ones_tick), .drv_oe(drv_oe)
  );

  typedef struct {
    int         ch;
    logic [1:0] m;
    string      tag;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  logic           mclk_run;
  logic [NCH-1:0] run, lvl;
  int   tick_cnt0, tick_cnt2;
  logic tick_en;

  // stimulus clocks, all driven away from the sampling edge
  initial begin
    int md, td;
    md = 0; td = 0;
    mclk_in = 1'b0; txclk = 4'b0101;
    forever begin
      @(negedge clk);
      md++; td++;
      if (md == 4) begin md = 0; if (mclk_run) mclk_in = ~mclk_in; end
      for (int i = 0; i < NCH; i++) begin
        if (!run[i]) txclk[i] = lvl[i];
        else if (td == 5) txclk[i] = ~txclk[i];
      end
      if (td == 5) td = 0;
    end
  end

  task automatic expect_mode(int ch, logic [1:0] m, string tag);
    exp_t e;
    e.ch = ch; e.m = m; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic drain();
    wait (q.size() == 0);
    @(negedge clk);
  endtask

  task automatic chk_int(bit ok, string tag, int act, int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0) begin
        exp_t e;
        logic [1:0] am;
        logic xo, xd;
        e  = q.pop_front();
        am = tx_mode[2*e.ch +: 2];
        xo = (e.m == 2'b00) || (e.m == 2'b01);
        xd = (e.m == 2'b01);
        checks++;
        if (am !== e.m || drv_oe[e.ch] !== xo || ones_data[e.ch] !== xd) begin
          errors++;
          $display("FAIL %s ch%0d actual mode=%b oe=%b ones=%b expected mode=%b oe=%b ones=%b",
                   e.tag, e.ch, am, drv_oe[e.ch], ones_data[e.ch], e.m, xo, xd);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (tick_en) begin
      tick_cnt0 += ones_tick[0];
      tick_cnt2 += ones_tick[2];
    end
  end

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic stick(int ch, logic v);
    run[ch] = 1'b0;
    lvl[ch] = v;
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; mclk_ok = 1'b1; ch1_ok = 1'b1;
    mclk_run = 1'b1; run = '1; lvl = '0;
    tick_en = 1'b0; tick_cnt0 = 0; tick_cnt2 = 0;
    repeat (6) @(negedge clk);
    for (int c = 0; c < NCH; c++) expect_mode(c, 2'b00, "R1 in reset");
    drain();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    for (int c = 0; c < NCH; c++) expect_mode(c, 2'b00, "R1 after reset");
    drain();

    // R2: all toggling
    repeat (20) @(posedge mclk_in);
    settle();
    for (int c = 0; c < NCH; c++) expect_mode(c, 2'b00, "R2 toggling");
    drain();

    // R3: ch0 stuck high
    stick(0, 1'b1);
    repeat (13) @(posedge mclk_in);
    settle();
    expect_mode(0, 2'b00, "R3 below limit");
    drain();
    repeat (6) @(posedge mclk_in);
    settle();
    expect_mode(0, 2'b01, "R3 all ones");
    expect_mode(2, 2'b00, "R10 neighbour normal");
    drain();

    // R9: strobe rate
    tick_cnt0 = 0; tick_cnt2 = 0;
    @(posedge mclk_in);
    tick_en = 1'b1;
    repeat (10) @(posedge mclk_in);
    tick_en = 1'b0;
    chk_int(tick_cnt0 >= 9 && tick_cnt0 <= 11, "R9 strobe count ch0", tick_cnt0, 10);
    chk_int(tick_cnt2 == 0, "R9 no strobe ch2", tick_cnt2, 0);

    // R5: recovery
    run[0] = 1'b1;
    repeat (3) @(posedge mclk_in);
    settle();
    expect_mode(0, 2'b00, "R5 recover from ones");
    drain();

    // R4: ch3 stuck low
    stick(3, 1'b0);
    repeat (60) @(posedge mclk_in);
    settle();
    expect_mode(3, 2'b00, "R4 below limit");
    drain();
    repeat (10) @(posedge mclk_in);
    settle();
    expect_mode(3, 2'b10, "R4 power down");
    expect_mode(1, 2'b00, "R10 ch1 normal");
    drain();
    run[3] = 1'b1;
    repeat (3) @(posedge mclk_in);
    settle();
    expect_mode(3, 2'b00, "R5 recover from down");
    drain();

    // R7: fall back to channel 1 clock
    mclk_ok = 1'b0; mclk_run = 1'b0;
    stick(2, 1'b1);
    repeat (13) @(posedge txclk[1]);
    settle();
    expect_mode(2, 2'b00, "R7 below limit");
    drain();
    repeat (6) @(posedge txclk[1]);
    settle();
    expect_mode(2, 2'b01, "R7 all ones on ch1 ref");
    expect_mode(1, 2'b00, "R7 ch1 normal");
    drain();
    run[2] = 1'b1;
    stick(0, 1'b0);
    repeat (70) @(posedge txclk[1]);
    settle();
    expect_mode(0, 2'b10, "R7 power down on ch1 ref");
    expect_mode(2, 2'b00, "R5 ch2 recovered");
    drain();
    run[0] = 1'b1;
    repeat (3) @(posedge txclk[1]);

    // R6: master flagged present but still, ch1 edges must not count
    mclk_ok = 1'b1;
    stick(3, 1'b1);
    repeat (30) @(posedge txclk[1]);
    settle();
    expect_mode(3, 2'b00, "R6 ch1 edges ignored");
    drain();
    mclk_run = 1'b1;
    repeat (20) @(posedge mclk_in);
    settle();
    expect_mode(3, 2'b01, "R6 master edges count");
    drain();
    run[3] = 1'b1;

    // R8: no reference at all
    mclk_ok = 1'b0; ch1_ok = 1'b0;
    settle();
    for (int c = 0; c < NCH; c++) expect_mode(c, 2'b11, "R8 no reference");
    drain();
    ch1_ok = 1'b1;
    repeat (4) @(posedge txclk[1]);
    settle();
    for (int c = 0; c < NCH; c++) expect_mode(c, 2'b00, "R8 reference back");
    drain();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule